// File: doc/BRIEF.md
# Processor State Image Reloader

This block reloads a processor's full architectural state from a memory image in one bulk operation. It restores the general registers, control and debug words, segment selectors and the hidden segment descriptor caches. It is started by a decoded two-byte opcode (escape byte 0x0F, then 0x07). It fetches the whole 51-dword image with no descriptor-table lookup and then commits everything at once.

The image address is the base held in the extra-segment descriptor cache plus the current destination-index register. Both values come from the block's own committed state. The image therefore chains: a load that writes a new extra-segment base and destination index sets where the next load reads from.

Image layout, by dword index:
- Indices 0..12 are plain 32-bit registers. Index 3 is the destination index.
- Indices 13..20 are eight selector slots.
- Indices 21..50 are ten descriptor-cache entries of three dwords each.
  - Entry 1 and entry 2 are the two table-register entries and carry no type byte.
  - Entry 9 is the extra segment.

The committed state can be read back through a view port. The view port is indexed by the same dword index, so each view word sits at the image position it was loaded from.

Top module: `state_reload`

## Requirements
- R1: A load starts only when `opValid` is high while the block is idle, with `opHi` = 0x0F and `opLo` = 0x07. Any other byte pair, or a trigger that arrives while a load is running, causes no memory read.
- R2: The image base is the committed base of cache entry 9 (view index 49) plus the committed destination index (view index 3). Both are taken at the moment the load starts.
- R3: A load issues exactly 51 reads, and read i goes to address base + 4*i, in ascending order.
- R4: `memReq` is a one-cycle pulse. No new request is made until `memValid` has answered the previous one.
- R5: View indices 0..12 return the image dwords 0..12 unchanged after a completed load.
- R6: Each selector slot (view indices 13..20) keeps bits 15:0 of its dword and reads back zero in bits 31:16.
- R7: The first dword of a cache entry (view index 21+3e) keeps only its type byte in bits 15:8, with all other bits zero. Entries 1 and 2 always hold a type byte of zero.
- R8: The base (view index 22+3e) and the limit (view index 23+3e) of every cache entry are stored exactly as read. The limit is never scaled or filled.
- R9: Nothing in the view changes before the load completes. `done` is high for exactly one cycle after the last read data, and the view shows the new state from the next cycle on.
- R10: `abort` while reads are in progress returns the block to idle. There is no `done` and no state change.
- R11: After reset, every view word is zero and `memReq` and `done` are low.
- R12: `memValid` with data while the block is idle, including a late answer to an aborted read, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Decoded opcode bytes are valid this cycle |
| opHi | input | 8 | First opcode byte |
| opLo | input | 8 | Second opcode byte |
| abort | input | 1 | Cancels a load in progress |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 32 | Byte address of the requested dword |
| memValid | input | 1 | Read data is valid |
| memData | input | 32 | Read data |
| done | output | 1 | One-cycle pulse when the new state is committed |
| viewIdx | input | 6 | Dword index of the committed state to view |
| viewData | output | 32 | Committed state word at `viewIdx`; zero above 50 |

## Verification
The bench uses the fixed 51-dword image with memory latencies of 0 to 3 cycles. This is small enough to sweep an abort at every one of the 51 read positions and to compare every view index after every completed load. Chained loads move the image base through values computed from the previous image, which exercises R2 on base values other than zero. Junk in the high halves of the selector slots and in the zero bytes of the cache type words checks the field extraction bit for bit.

// File: rtl/state_reload_pkg.sv
package state_reload_pkg;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 32;
  localparam int GEN_WORDS     = 13;
  localparam int SEL_SLOTS     = 8;
  localparam int CACHE_ENTRIES = 10;
  localparam int CACHE_WORDS   = 3;
  localparam int SEL_W         = 16;
  localparam int TYPE_W        = 8;
  localparam int SEL_BASE      = GEN_WORDS;
  localparam int CACHE_BASE    = GEN_WORDS + SEL_SLOTS;
  localparam int TABLE_WORDS   = CACHE_BASE + CACHE_ENTRIES * CACHE_WORDS;
  localparam int IDX_W         = $clog2(TABLE_WORDS);
  localparam int EDI_SLOT      = 3;
  localparam int ES_ENTRY      = 9;
  localparam int IDT_ENTRY     = 1;
  localparam int GDT_ENTRY     = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_COMMIT} seqState_t;

  typedef struct packed {
    logic             loadBase;
    logic             issue;
    logic             capture;
    logic             commit;
    logic [IDX_W-1:0] wordIdx;
  } seqStrobe_t;
endpackage

// File: rtl/state_reload_ctrl.sv
module state_reload_ctrl
  import state_reload_pkg::*;
#(
  parameter logic [7:0] OPC_ESC    = 8'h0F,
  parameter logic [7:0] OPC_RELOAD = 8'h07
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opHi,
  input  logic [7:0] opLo,
  input  logic       abort,
  input  logic       memValid,
  output seqStrobe_t strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_WORDS - 1);

  seqState_t        state;
  logic [IDX_W-1:0] wordIdx;
  logic             opHit;

  assign opHit = opValid && (opHi == OPC_ESC) && (opLo == OPC_RELOAD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (opHit) begin
            state   <= ST_ISSUE;
            wordIdx <= '0;
          end
        end
        ST_ISSUE: state <= abort ? ST_IDLE : ST_WAIT;
        ST_WAIT: begin
          if (abort) begin
            state <= ST_IDLE;
          end else if (memValid) begin
            if (wordIdx == LAST_IDX) begin
              state <= ST_COMMIT;
            end else begin
              wordIdx <= wordIdx + 1'b1;
              state   <= ST_ISSUE;
            end
          end
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadBase = (state == ST_IDLE) && opHit;
    strobe.issue    = (state == ST_ISSUE) && !abort;
    strobe.capture  = (state == ST_WAIT) && memValid && !abort;
    strobe.commit   = (state == ST_COMMIT);
    strobe.wordIdx  = wordIdx;
  end
endmodule

// File: rtl/state_reload_dp.sv
module state_reload_dp
  import state_reload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [IDX_W-1:0]  viewIdx,
  output logic [DATA_W-1:0] viewData
);
  logic [ADDR_W-1:0] baseReg;
  logic [DATA_W-1:0] shadow     [TABLE_WORDS];
  logic [DATA_W-1:0] genReg     [GEN_WORDS];
  logic [SEL_W-1:0]  selReg     [SEL_SLOTS];
  logic [TYPE_W-1:0] cacheType  [CACHE_ENTRIES];
  logic [ADDR_W-1:0] cacheBase  [CACHE_ENTRIES];
  logic [DATA_W-1:0] cacheLimit [CACHE_ENTRIES];
  logic [DATA_W-1:0] viewArr    [TABLE_WORDS];

  assign memAddr = baseReg + {{(ADDR_W-IDX_W-2){1'b0}}, strobe.wordIdx, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseReg <= '0;
    else if (strobe.loadBase) baseReg <= cacheBase[ES_ENTRY] + genReg[EDI_SLOT];
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) shadow[strobe.wordIdx] <= memData;
  end

  for (genvar g = 0; g < GEN_WORDS; g++) begin : g_gen
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) genReg[g] <= '0;
      else if (strobe.commit) genReg[g] <= shadow[g];
    end
    assign viewArr[g] = genReg[g];
  end

  for (genvar s = 0; s < SEL_SLOTS; s++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selReg[s] <= '0;
      else if (strobe.commit) selReg[s] <= shadow[SEL_BASE + s][SEL_W-1:0];
    end
    assign viewArr[SEL_BASE + s] = {{(DATA_W-SEL_W){1'b0}}, selReg[s]};
  end

  for (genvar e = 0; e < CACHE_ENTRIES; e++) begin : g_cache
    localparam int W0 = CACHE_BASE + CACHE_WORDS * e;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cacheBase[e]  <= '0;
        cacheLimit[e] <= '0;
      end else if (strobe.commit) begin
        cacheBase[e]  <= shadow[W0 + 1];
        cacheLimit[e] <= shadow[W0 + 2];
      end
    end
    if (e == IDT_ENTRY || e == GDT_ENTRY) begin : g_notype
      assign cacheType[e] = '0;
    end else begin : g_type
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cacheType[e] <= '0;
        else if (strobe.commit) cacheType[e] <= shadow[W0][2*TYPE_W-1:TYPE_W];
      end
    end
    assign viewArr[W0]     = {{(DATA_W-2*TYPE_W){1'b0}}, cacheType[e], {TYPE_W{1'b0}}};
    assign viewArr[W0 + 1] = cacheBase[e];
    assign viewArr[W0 + 2] = cacheLimit[e];
  end

  assign viewData = (viewIdx < IDX_W'(TABLE_WORDS)) ? viewArr[viewIdx] : '0;
endmodule

// File: rtl/state_reload.sv
module state_reload
  import state_reload_pkg::*;
#(
  parameter logic [7:0] OPC_ESC    = 8'h0F,
  parameter logic [7:0] OPC_RELOAD = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [7:0]  opHi,
  input  logic [7:0]  opLo,
  input  logic        abort,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memValid,
  input  logic [31:0] memData,
  output logic        done,
  input  logic [5:0]  viewIdx,
  output logic [31:0] viewData
);
  seqStrobe_t strobe;

  state_reload_ctrl #(.OPC_ESC(OPC_ESC), .OPC_RELOAD(OPC_RELOAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opHi(opHi), .opLo(opLo),
    .abort(abort), .memValid(memValid), .strobe(strobe)
  );

  state_reload_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memData(memData),
    .memAddr(memAddr), .viewIdx(viewIdx), .viewData(viewData)
  );

  assign memReq = strobe.issue;
  assign done   = strobe.commit;
endmodule

// File: rtl/state_reload_chk.sv
module state_reload_chk
  import state_reload_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        abort,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        memValid,
  input logic        done
);
  logic        pending;
  logic [6:0]  reqCnt;
  logic [31:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      reqCnt   <= '0;
      lastAddr <= '0;
    end else begin
      if (memReq) pending <= 1'b1;
      else if (memValid || abort) pending <= 1'b0;
      if (done || abort) reqCnt <= '0;
      else if (memReq) reqCnt <= reqCnt + 1'b1;
      if (memReq) lastAddr <= memAddr;
    end
  end

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !pending);
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && reqCnt != 0) |-> memAddr == lastAddr + 32'd4);
  p_read_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> reqCnt < 7'(TABLE_WORDS));
  p_done_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqCnt == 7'(TABLE_WORDS));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rstN |-> (!memReq && !done));
endmodule

bind state_reload state_reload_chk u_chk (
  .clk(clk), .rstN(rstN), .abort(abort), .memReq(memReq),
  .memAddr(memAddr), .memValid(memValid), .done(done)
);

// File: tb/state_reload_bench.sv
module state_reload_bench;
  localparam int NW = 51;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opHi = 8'h00, opLo = 8'h00;
  logic        abort = 1'b0;
  logic        memReq, done;
  logic [31:0] memAddr, viewData;
  logic        memValid = 1'b0;
  logic [31:0] memData = 32'h0;
  logic [5:0]  viewIdx = 6'd0;

  int checks = 0, fails = 0;
  logic [31:0] expView [NW];
  int curSeed;
  logic [31:0] curBase;

  always #5 clk = ~clk;

  state_reload u_state_reload (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opHi(opHi), .opLo(opLo),
    .abort(abort), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .done(done), .viewIdx(viewIdx), .viewData(viewData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] img(input int seed, input int i);
    if (i == 3)  return 32'h0000_0400 * seed[31:0];
    if (i == 49) return 32'h0010_0000 * seed[31:0] + 32'h40;
    return (i * 32'h0100_0193) ^ (seed * 32'h9E37_79B9) ^ 32'hA5A5_5A5A;
  endfunction

  // field extraction expected at view index i from image word w (R5..R8)
  function automatic logic [31:0] viewOf(input int i, input logic [31:0] w);
    int e, k;
    if (i < 13) return w;
    if (i < 21) return {16'h0, w[15:0]};
    e = (i - 21) / 3;
    k = (i - 21) % 3;
    if (k == 0) return (e == 1 || e == 2) ? 32'h0 : {16'h0, w[15:8], 8'h0};
    return w;
  endfunction

  function automatic string tagOf(input int i);
    if (i < 13) return "R5";
    if (i < 21) return "R6";
    if (((i - 21) % 3) == 0) return "R7";
    return "R8";
  endfunction

  task automatic checkView(input string tag);
    for (int i = 0; i < NW; i++) begin
      viewIdx = 6'(i);
      #1;
      chk(viewData === expView[i], tag, viewData, expView[i]);
    end
  endtask

  // one load; abortAt < 0 means no abort; retrigAt >= 0 re-pulses trigger mid-run
  task automatic runLoad(input int seed, input int lat, input int abortAt,
                         input int retrigAt, input logic [7:0] hi, input logic [7:0] lo);
    int reqCount = 0, doneCount = 0, addrErr = 0, overlap = 0, cyc = 0, idleCyc = 0;
    bit pend = 0, aborted = 0, finished = 0;
    int pCnt = 0;
    logic [31:0] pAddr = 0;
    logic [31:0] oldEdi;
    curSeed = seed;
    curBase = expView[49] + expView[3];
    oldEdi  = expView[3];
    @(negedge clk);
    opValid = 1'b1; opHi = hi; opLo = lo;
    @(negedge clk);
    opValid = 1'b0;
    while (!finished && cyc < 2000) begin
      cyc++;
      abort = (abortAt >= 0 && !aborted && reqCount == abortAt + 1 && !pend) ? 1'b0 : abort;
      if (abortAt >= 0 && !aborted && reqCount >= abortAt) begin
        abort = 1'b1; aborted = 1;
      end else abort = 1'b0;
      if (retrigAt >= 0 && reqCount == retrigAt) begin
        opValid = 1'b1; opHi = 8'h0F; opLo = 8'h07;
      end else opValid = 1'b0;
      #1;
      memValid = 1'b0;
      if (pend) begin
        if (pCnt == 0) begin
          memValid = 1'b1;
          memData  = img(curSeed, int'((pAddr - curBase) >> 2));
          pend = 0;
        end else pCnt--;
      end
      if (memReq) begin
        if (pend) overlap++;
        if (memAddr !== curBase + 32'(4 * reqCount)) addrErr++;
        reqCount++;
        pend = 1; pCnt = lat; pAddr = memAddr;
      end
      if (done) begin
        doneCount++;
        viewIdx = 6'd3;
        #1;
        chk(viewData === oldEdi, "R9 view unchanged in done cycle", viewData, oldEdi);
      end
      if (doneCount > 0 || aborted || hi != 8'h0F || lo != 8'h07) idleCyc++;
      if (idleCyc > 8) finished = 1;
      @(negedge clk);
    end
    abort = 1'b0; opValid = 1'b0; memValid = 1'b0;
    repeat (3) @(negedge clk);
    if (hi != 8'h0F || lo != 8'h07) begin
      chk(reqCount == 0, "R1 wrong opcode issues no read", reqCount, 0);
      checkView("R1 state unchanged");
    end else if (abortAt >= 0) begin
      chk(doneCount == 0, "R10 no done after abort", doneCount, 0);
      chk(reqCount <= abortAt + 1, "R10 reads stop at abort", reqCount, abortAt + 1);
      checkView("R10/R12 state unchanged after abort");
    end else begin
      chk(reqCount == NW, "R3 read count", reqCount, NW);
      chk(addrErr == 0, "R2/R3 address sequence", addrErr, 0);
      chk(overlap == 0, "R4 single outstanding read", overlap, 0);
      chk(doneCount == 1, "R9 single done pulse", doneCount, 1);
      if (retrigAt >= 0) chk(reqCount == NW, "R1 retrigger while busy ignored", reqCount, NW);
      for (int i = 0; i < NW; i++) expView[i] = viewOf(i, img(seed, i));
      checkView(tagOf(0));
      for (int i = 13; i < NW; i++) begin
        viewIdx = 6'(i);
        #1;
        chk(viewData === expView[i], tagOf(i), viewData, expView[i]);
      end
    end
  endtask

  bit wdFired = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wdFired = 1;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) expView[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(memReq === 1'b0, "R11 memReq low in reset", memReq, 0);
    chk(done === 1'b0, "R11 done low in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkView("R11 reset view zero");
    viewIdx = 6'd60;
    #1;
    chk(viewData === 32'h0, "R11 view above range is zero", viewData, 0);

    runLoad(1, 0, -1, -1, 8'h0F, 8'h05);
    runLoad(1, 0, -1, -1, 8'h0E, 8'h07);
    for (int s = 1; s <= 6; s++)
      for (int l = 0; l < 4; l++)
        runLoad(s * 4 + l, l, -1, -1, 8'h0F, 8'h07);
    runLoad(40, 2, -1, 10, 8'h0F, 8'h07);
    for (int k = 0; k < NW; k++)
      runLoad(100 + k, 1 + (k % 3), k, -1, 8'h0F, 8'h07);

    // R12: stray data while idle
    for (int i = 0; i < 4; i++) begin
      memValid = 1'b1; memData = 32'hDEAD_0000 + 32'(i);
      @(negedge clk);
    end
    memValid = 1'b0;
    chk(memReq === 1'b0, "R12 no request from idle data", memReq, 0);
    checkView("R12 state unchanged by idle data");

    if (!wdFired) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule